// File: doc/BRIEF.md
# Write-Through Data Cache with DMA Snoop Invalidate

This block is a small direct-mapped data cache between a 32-bit CPU load/store port and a memory bus that can return bursts. A load that hits returns its word in the cycle it is presented. A load that misses is turned into one read request on the memory bus. The returned words are written into the line, and the CPU is released as soon as the word it asked for arrives. Every store goes through to memory. A store that hits also updates the cached copy under its byte enables. Lines are therefore never dirty, and dropping a line never needs a write-back.

A snoop port watches addresses written by a DMA master. When snooping is enabled and such an address falls inside a valid cached line, the line is invalidated. A global invalidate input empties the whole cache in one cycle.

A configuration input selects the refill length. It is either a whole 4-word line or only the single missing word. Validity is kept per word within a line, so a single-word refill marks only that word usable.

Top module: `dcache_wt`

## Requirements
- R1: After reset every word is invalid, so the first load to any address misses.
- R2: A load that hits raises cpu_ready_o in the same cycle it is presented and returns the cached word on cpu_rdata_o, with no memory request.
- R3: A load miss issues one memory read whose mem_addr_o is the word-aligned address of the missing word. cpu_ready_o stays low until the first returned beat and rises in that beat's cycle with that beat's data.
- R4: With cfg_burst4_i high, mem_len_o is 3 and the four beats fill the line in wrapped order starting at the missing word. All four words then hit.
- R5: With cfg_burst4_i low, mem_len_o is 0 and only the missing word becomes valid. The other words of the line still miss.
- R6: Every store issues a memory write with the CPU address, data and byte enables, and completes (cpu_ready_o high) in the cycle of mem_ack_i. A store that hits merges the enabled bytes into the cached word.
- R7: A store that misses allocates nothing, so a later load to that address misses.
- R8: With snoop_en_i and snoop_valid_i high, a snoop address inside a valid cached line invalidates the whole line from the next cycle. With snoop_en_i low the snoop has no effect.
- R9: A snoop or global invalidate that hits the line under refill, in any cycle of the refill, leaves that line invalid. The CPU still receives its word.
- R10: inv_all_i clears every valid bit at the next clock edge, taking priority over any fill in that cycle.
- R11: A load miss to an index whose line holds another tag replaces the line, so the old address misses afterwards.
- R12: mem_req_o, mem_addr_o and mem_we_o hold steady until mem_ack_i. A store completes one cycle after mem_ack_wait cycles of delay plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | CPU access request, held until cpu_ready_o |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 32 | Byte address |
| cpu_be_i | input | 4 | Store byte enables |
| cpu_wdata_i | input | 32 | Store data |
| cpu_ready_o | output | 1 | Access completes this cycle |
| cpu_rdata_o | output | 32 | Load data, valid with cpu_ready_o |
| cfg_burst4_i | input | 1 | 1 = refill whole line, 0 = refill one word |
| snoop_en_i | input | 1 | Snoop invalidation enable |
| snoop_valid_i | input | 1 | DMA write address present |
| snoop_addr_i | input | 32 | DMA write byte address |
| inv_all_i | input | 1 | Invalidate every line |
| mem_req_o | output | 1 | Memory request, held until mem_ack_i |
| mem_we_o | output | 1 | 1 = write, 0 = burst read |
| mem_addr_o | output | 32 | Request address (critical word for reads) |
| mem_be_o | output | 4 | Write byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_len_o | output | 2 | Read beats minus one |
| mem_ack_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read beat present |
| mem_rdata_i | input | 32 | Read beat data |

## Verification
A hit is due in the presentation cycle itself. With an immediate acknowledge, a load miss releases the CPU two cycles after presentation: one cycle in the request state, then the first beat. A store completes one cycle after presentation plus the acknowledge delay. The bench drives at the falling edge and samples 1 ns later, before the next rising edge. It counts those samples until ready and compares the count against these exact figures. Before each check for a hit, it waits out any refill beats still in flight, so a lingering burst cannot be mistaken for a stall.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RREQ,
    ST_RDAT,
    ST_WREQ
  } dc_state_e;
endpackage

// File: rtl/dcache_tag_array.sv
module dcache_tag_array #(
  parameter int LINES      = 64,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 22,
  localparam int IDX_W     = $clog2(LINES),
  localparam int WOFF_W    = $clog2(LINE_WORDS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        inv_all_i,
  input  logic [IDX_W-1:0]            lk_idx_i,
  input  logic [TAG_W-1:0]            lk_tag_i,
  input  logic [WOFF_W-1:0]           lk_word_i,
  output logic                        lk_hit_o,
  input  logic                        snp_fire_i,
  input  logic [IDX_W-1:0]            snp_idx_i,
  input  logic [TAG_W-1:0]            snp_tag_i,
  output logic                        snp_hit_o,
  input  logic                        alloc_i,
  input  logic                        fill_i,
  input  logic [IDX_W-1:0]            fill_idx_i,
  input  logic [WOFF_W-1:0]           fill_word_i,
  output logic [LINES*LINE_WORDS-1:0] valid_o
);
  logic [TAG_W-1:0]      tag_q   [LINES];
  logic [LINE_WORDS-1:0] valid_q [LINES];

  assign lk_hit_o  = (tag_q[lk_idx_i] == lk_tag_i) && valid_q[lk_idx_i][lk_word_i];
  assign snp_hit_o = snp_fire_i && (tag_q[snp_idx_i] == snp_tag_i) && (|valid_q[snp_idx_i]);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel_alloc, sel_fill, sel_snp;
    assign sel_alloc = alloc_i && (lk_idx_i == IDX_W'(i)) && (tag_q[i] != lk_tag_i);
    assign sel_fill  = fill_i && (fill_idx_i == IDX_W'(i));
    assign sel_snp   = snp_hit_o && (snp_idx_i == IDX_W'(i));
    assign valid_o[i*LINE_WORDS +: LINE_WORDS] = valid_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[i]   <= '0;
        valid_q[i] <= '0;
      end else if (inv_all_i) begin
        valid_q[i] <= '0;
      end else begin
        if (sel_alloc) begin
          tag_q[i]   <= lk_tag_i;
          valid_q[i] <= '0;
        end
        if (sel_fill) valid_q[i][fill_word_i] <= 1'b1;
        // snoop wins over fill in the same cycle
        if (sel_snp) valid_q[i] <= '0;
      end
    end
  end
endmodule

// File: rtl/dcache_data_array.sv
module dcache_data_array #(
  parameter int LINES      = 64,
  parameter int LINE_WORDS = 4,
  parameter int DW         = 32,
  localparam int IDX_W     = $clog2(LINES),
  localparam int WOFF_W    = $clog2(LINE_WORDS),
  localparam int BW        = DW / 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  w_idx_i,
  input  logic [WOFF_W-1:0] w_word_i,
  input  logic [BW-1:0]     w_be_i,
  input  logic [DW-1:0]     w_data_i,
  input  logic [IDX_W-1:0]  r_idx_i,
  input  logic [WOFF_W-1:0] r_word_i,
  output logic [DW-1:0]     r_data_o
);
  localparam int WORDS = LINES * LINE_WORDS;

  logic [DW-1:0] mem_q [WORDS];
  logic [IDX_W+WOFF_W-1:0] w_ptr, r_ptr;

  assign w_ptr    = {w_idx_i, w_word_i};
  assign r_ptr    = {r_idx_i, r_word_i};
  assign r_data_o = mem_q[r_ptr];

  for (genvar b = 0; b < BW; b++) begin : g_byte
    always_ff @(posedge clk_i) begin
      if (we_i && w_be_i[b]) mem_q[w_ptr][b*8 +: 8] <= w_data_i[b*8 +: 8];
    end
  end
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_WORDS = 4,
  localparam int BW        = DW / 8,
  localparam int OFF_W     = $clog2(BW),
  localparam int WOFF_W    = $clog2(LINE_WORDS),
  localparam int LA_W      = AW - OFF_W - WOFF_W,
  localparam int WA_W      = AW - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [AW-1:0]     cpu_addr_i,
  input  logic [BW-1:0]     cpu_be_i,
  input  logic [DW-1:0]     cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DW-1:0]     cpu_rdata_o,
  input  logic              cfg_burst4_i,
  input  logic              snoop_fire_i,
  input  logic [LA_W-1:0]   snoop_line_i,
  input  logic              inv_all_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BW-1:0]     mem_be_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic [WOFF_W-1:0] mem_len_o,
  input  logic              mem_ack_i,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic [WA_W-1:0]   lk_waddr_o,
  input  logic              lk_hit_i,
  input  logic [DW-1:0]     arr_rdata_i,
  output logic              alloc_o,
  output logic              fill_o,
  output logic              dw_en_o,
  output logic [WOFF_W-1:0] dw_word_o,
  output logic [BW-1:0]     dw_be_o,
  output logic [DW-1:0]     dw_data_o
);
  dc_state_e         state_q, state_d;
  logic [AW-1:0]     addr_q;
  logic [BW-1:0]     be_q;
  logic [DW-1:0]     wdata_q;
  logic              burst4_q, kill_q, kill_d;
  logic [WOFF_W-1:0] beat_q, beat_d, last_beat, crit_word;
  logic [LA_W-1:0]   cur_line;
  logic              kill_now, accept;

  assign lk_waddr_o = (state_q == ST_IDLE) ? cpu_addr_i[AW-1:OFF_W] : addr_q[AW-1:OFF_W];
  assign cur_line   = lk_waddr_o[WA_W-1:WOFF_W];
  assign crit_word  = addr_q[OFF_W +: WOFF_W];
  assign last_beat  = burst4_q ? WOFF_W'(LINE_WORDS - 1) : '0;
  assign kill_now   = inv_all_i || (snoop_fire_i && (snoop_line_i == cur_line));
  assign accept     = (state_q == ST_IDLE) && cpu_req_i && (cpu_we_i || !lk_hit_i);

  always_comb begin
    state_d     = state_q;
    beat_d      = beat_q;
    kill_d      = kill_q;
    cpu_ready_o = 1'b0;
    cpu_rdata_o = arr_rdata_i;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = {addr_q[AW-1:OFF_W], {OFF_W{1'b0}}};
    mem_be_o    = '1;
    mem_wdata_o = wdata_q;
    mem_len_o   = '0;
    alloc_o     = 1'b0;
    fill_o      = 1'b0;
    dw_en_o     = 1'b0;
    dw_word_o   = crit_word;
    dw_be_o     = be_q;
    dw_data_o   = wdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req_i) begin
          if (cpu_we_i) begin
            state_d = ST_WREQ;
          end else if (lk_hit_i) begin
            cpu_ready_o = 1'b1;
          end else begin
            alloc_o = 1'b1;
            kill_d  = kill_now;
            state_d = ST_RREQ;
          end
        end
      end
      ST_RREQ: begin
        mem_req_o = 1'b1;
        mem_len_o = burst4_q ? WOFF_W'(LINE_WORDS - 1) : '0;
        kill_d    = kill_q || kill_now;
        if (mem_ack_i) begin
          beat_d  = '0;
          state_d = ST_RDAT;
        end
      end
      ST_RDAT: begin
        kill_d = kill_q || kill_now;
        if (mem_rvalid_i) begin
          dw_en_o   = 1'b1;
          dw_word_o = crit_word + beat_q;
          dw_be_o   = '1;
          dw_data_o = mem_rdata_i;
          fill_o    = !(kill_q || kill_now);
          if (beat_q == '0) begin
            cpu_ready_o = 1'b1;
            cpu_rdata_o = mem_rdata_i;
          end
          beat_d = beat_q + 1'b1;
          if (beat_q == last_beat) state_d = ST_IDLE;
        end
      end
      ST_WREQ: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = addr_q;
        mem_be_o   = be_q;
        if (mem_ack_i) begin
          cpu_ready_o = 1'b1;
          dw_en_o     = lk_hit_i;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      be_q     <= '0;
      wdata_q  <= '0;
      burst4_q <= 1'b0;
      beat_q   <= '0;
      kill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      kill_q  <= kill_d;
      if (accept) begin
        addr_q   <= cpu_addr_i;
        be_q     <= cpu_be_i;
        wdata_q  <= cpu_wdata_i;
        burst4_q <= cfg_burst4_i;
      end
    end
  end
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int CACHE_BYTES = 1024,
  parameter int LINE_WORDS  = 4,
  localparam int BW         = DW / 8,
  localparam int OFF_W      = $clog2(BW),
  localparam int WOFF_W     = $clog2(LINE_WORDS),
  localparam int LINES      = CACHE_BYTES / (BW * LINE_WORDS),
  localparam int IDX_W      = $clog2(LINES),
  localparam int TAG_W      = AW - IDX_W - WOFF_W - OFF_W,
  localparam int LA_W       = AW - OFF_W - WOFF_W,
  localparam int WA_W       = AW - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [AW-1:0]     cpu_addr_i,
  input  logic [BW-1:0]     cpu_be_i,
  input  logic [DW-1:0]     cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DW-1:0]     cpu_rdata_o,
  input  logic              cfg_burst4_i,
  input  logic              snoop_en_i,
  input  logic              snoop_valid_i,
  input  logic [AW-1:0]     snoop_addr_i,
  input  logic              inv_all_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BW-1:0]     mem_be_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic [WOFF_W-1:0] mem_len_o,
  input  logic              mem_ack_i,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i
);
  logic [WA_W-1:0]             lk_waddr;
  logic [IDX_W-1:0]            lk_idx;
  logic [TAG_W-1:0]            lk_tag;
  logic [WOFF_W-1:0]           lk_word;
  logic                        lk_hit, snp_hit, snoop_fire;
  logic                        alloc, fill, dw_en;
  logic [WOFF_W-1:0]           dw_word;
  logic [BW-1:0]               dw_be;
  logic [DW-1:0]               dw_data, arr_rdata;
  logic [LA_W-1:0]             snoop_line;
  logic [LINES*LINE_WORDS-1:0] valid_flat;
  logic                        snoop_unused;

  assign lk_word      = lk_waddr[WOFF_W-1:0];
  assign lk_idx       = lk_waddr[WOFF_W +: IDX_W];
  assign lk_tag       = lk_waddr[WA_W-1 -: TAG_W];
  assign snoop_fire   = snoop_en_i && snoop_valid_i;
  assign snoop_line   = snoop_addr_i[AW-1:OFF_W+WOFF_W];
  assign snoop_unused = ^snoop_addr_i[OFF_W+WOFF_W-1:0];

  dcache_ctrl #(.AW(AW), .DW(DW), .LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_be_i, .cpu_wdata_i,
    .cpu_ready_o, .cpu_rdata_o, .cfg_burst4_i,
    .snoop_fire_i (snoop_fire),
    .snoop_line_i (snoop_line),
    .inv_all_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o, .mem_len_o,
    .mem_ack_i, .mem_rvalid_i, .mem_rdata_i,
    .lk_waddr_o   (lk_waddr),
    .lk_hit_i     (lk_hit),
    .arr_rdata_i  (arr_rdata),
    .alloc_o      (alloc),
    .fill_o       (fill),
    .dw_en_o      (dw_en),
    .dw_word_o    (dw_word),
    .dw_be_o      (dw_be),
    .dw_data_o    (dw_data)
  );

  dcache_tag_array #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni, .inv_all_i,
    .lk_idx_i    (lk_idx),
    .lk_tag_i    (lk_tag),
    .lk_word_i   (lk_word),
    .lk_hit_o    (lk_hit),
    .snp_fire_i  (snoop_fire),
    .snp_idx_i   (snoop_line[IDX_W-1:0]),
    .snp_tag_i   (snoop_line[LA_W-1 -: TAG_W]),
    .snp_hit_o   (snp_hit),
    .alloc_i     (alloc),
    .fill_i      (fill),
    .fill_idx_i  (lk_idx),
    .fill_word_i (dw_word),
    .valid_o     (valid_flat)
  );

  dcache_data_array #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .DW(DW)) u_data (
    .clk_i,
    .we_i     (dw_en),
    .w_idx_i  (lk_idx),
    .w_word_i (dw_word),
    .w_be_i   (dw_be),
    .w_data_i (dw_data),
    .r_idx_i  (lk_idx),
    .r_word_i (lk_word),
    .r_data_o (arr_rdata)
  );
endmodule

// File: rtl/dcache_wt_chk.sv
module dcache_wt_chk #(
  parameter int AW         = 32,
  parameter int LINES      = 64,
  parameter int LINE_WORDS = 4,
  parameter int BW         = 4,
  localparam int OFF_W     = $clog2(BW),
  localparam int WOFF_W    = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(LINES)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        cpu_req_i,
  input logic                        cpu_we_i,
  input logic                        cpu_ready_o,
  input logic                        inv_all_i,
  input logic [AW-1:0]               snoop_addr_i,
  input logic                        snp_hit,
  input logic                        mem_req_o,
  input logic                        mem_we_o,
  input logic                        mem_ack_i,
  input logic [AW-1:0]               mem_addr_o,
  input logic [WOFF_W-1:0]           mem_len_o,
  input logic [LINES*LINE_WORDS-1:0] valid_flat
);
  logic [IDX_W-1:0] snp_idx;
  assign snp_idx = snoop_addr_i[OFF_W+WOFF_W +: IDX_W];

  // R12
  a_r12_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o);
  a_r12_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> $stable(mem_addr_o) && $stable(mem_we_o));
  // R6
  a_r6_store_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_we_i && cpu_ready_o |-> mem_req_o && mem_we_o && mem_ack_i);
  a_r6_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_len_o == '0);
  // R10
  a_r10_inv_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> valid_flat == '0);
  // R8
  a_r8_snoop_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_hit |=> valid_flat[$past(snp_idx)*LINE_WORDS +: LINE_WORDS] == '0);
endmodule

bind dcache_wt dcache_wt_chk #(.AW(AW), .LINES(LINES), .LINE_WORDS(LINE_WORDS), .BW(BW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_req_i    (cpu_req_i),
  .cpu_we_i     (cpu_we_i),
  .cpu_ready_o  (cpu_ready_o),
  .inv_all_i    (inv_all_i),
  .snoop_addr_i (snoop_addr_i),
  .snp_hit      (snp_hit),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_ack_i    (mem_ack_i),
  .mem_addr_o   (mem_addr_o),
  .mem_len_o    (mem_len_o),
  .valid_flat   (valid_flat)
);

// File: tb/dcache_wt_tb.sv
`timescale 1ns/1ps
module dcache_wt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        cpu_ready_o;
  logic [31:0] cpu_rdata_o;
  logic        cfg_burst4 = 1'b1, snoop_en = 0, snoop_valid = 0, inv_all = 0;
  logic [31:0] snoop_addr = '0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic [1:0]  mem_len_o;
  logic        mem_ack = 0, mem_rvalid = 0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, failures = 0;
  int ack_wait = 0, wait_cnt = 0, beats_left = 0, n_reads = 0, n_writes = 0;
  logic [9:0]  rd_word = '0;
  logic [31:0] last_rd_addr = '0, last_w_addr = '0, last_w_data = '0;
  logic [1:0]  last_len = '0;
  logic [3:0]  last_w_be = '0;
  logic [31:0] mem [1024];

  always #2.5 clk = ~clk;

  dcache_wt u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_be_i(cpu_be),
    .cpu_wdata_i(cpu_wdata), .cpu_ready_o, .cpu_rdata_o,
    .cfg_burst4_i(cfg_burst4), .snoop_en_i(snoop_en), .snoop_valid_i(snoop_valid),
    .snoop_addr_i(snoop_addr), .inv_all_i(inv_all),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o, .mem_len_o,
    .mem_ack_i(mem_ack), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  // memory responder, drives at falling edges
  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 ^ (32'(i) * 32'h0001_0101);
    forever begin
      @(negedge clk);
      mem_ack = 0; mem_rvalid = 0;
      if (beats_left > 0) begin
        mem_rvalid = 1; mem_rdata = mem[rd_word];
        rd_word = {rd_word[9:2], rd_word[1:0] + 2'd1};
        beats_left--;
      end else if (mem_req_o) begin
        if (wait_cnt < ack_wait) wait_cnt++;
        else begin
          wait_cnt = 0; mem_ack = 1;
          if (mem_we_o) begin
            for (int b = 0; b < 4; b++)
              if (mem_be_o[b]) mem[mem_addr_o[11:2]][b*8 +: 8] = mem_wdata_o[b*8 +: 8];
            last_w_addr = mem_addr_o; last_w_data = mem_wdata_o; last_w_be = mem_be_o;
            n_writes++;
          end else begin
            last_rd_addr = mem_addr_o; last_len = mem_len_o;
            rd_word = mem_addr_o[11:2]; beats_left = int'(mem_len_o) + 1;
            n_reads++;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic cpu_load(input logic [31:0] a, output logic [31:0] d, output int stall);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a; stall = 0;
    #1;
    while (!cpu_ready_o && stall < 100) begin @(negedge clk); #1; stall++; end
    d = cpu_rdata_o;
    @(negedge clk); cpu_req = 0;
    settle();
  endtask

  task automatic cpu_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, output int stall);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; cpu_be = be; stall = 0;
    #1;
    while (!cpu_ready_o && stall < 100) begin @(negedge clk); #1; stall++; end
    @(negedge clk); cpu_req = 0; cpu_we = 0;
    settle();
  endtask

  task automatic snoop_pulse(input logic en, input logic [31:0] a);
    @(negedge clk); snoop_en = en; snoop_valid = 1; snoop_addr = a;
    @(negedge clk); snoop_valid = 0; snoop_en = 0;
  endtask

  task automatic t_reset_miss();
    logic [31:0] d; int st, r0;
    check(cpu_ready_o == 0, "R1 idle ready", 32'(cpu_ready_o), 0);
    r0 = n_reads;
    cpu_load(32'h48, d, st);
    check(st == 2, "R1 R3 first load stall", st, 2);
    check(d == mem[18], "R3 critical data", d, mem[18]);
    check(n_reads == r0 + 1 && last_rd_addr == 32'h48, "R3 read addr", last_rd_addr, 32'h48);
    check(last_len == 2'd3, "R4 burst len", 32'(last_len), 3);
  endtask

  task automatic t_burst4_hits();
    logic [31:0] d; int st, r0;
    r0 = n_reads;
    for (int w = 0; w < 4; w++) begin
      cpu_load(32'h40 + 32'(w*4), d, st);
      check(st == 0, "R2 R4 hit stall", st, 0);
      check(d == mem[16+w], "R2 R4 wrapped fill data", d, mem[16+w]);
    end
    check(n_reads == r0, "R2 no mem read on hit", n_reads, r0);
  endtask

  task automatic t_burst1();
    logic [31:0] d; int st;
    cfg_burst4 = 0;
    cpu_load(32'h200, d, st);
    check(st == 2 && last_len == 2'd0, "R5 single beat len", 32'(last_len), 0);
    check(d == mem[128], "R5 data", d, mem[128]);
    cpu_load(32'h204, d, st);
    check(st == 2, "R5 neighbour still misses", st, 2);
    cpu_load(32'h200, d, st);
    check(st == 0 && d == mem[128], "R5 fetched word hits", d, mem[128]);
    cfg_burst4 = 1;
  endtask

  task automatic t_store_hit();
    logic [31:0] d, exp; int st, w0;
    w0 = n_writes;
    exp = {mem[17][31:16], 16'h3344};
    cpu_store(32'h44, 32'h1122_3344, 4'b0011, st);
    check(st == 1, "R6 store completes on ack", st, 1);
    check(n_writes == w0 + 1 && last_w_addr == 32'h44, "R6 write addr", last_w_addr, 32'h44);
    check(last_w_data == 32'h1122_3344 && last_w_be == 4'b0011, "R6 write data/be", last_w_data, 32'h1122_3344);
    cpu_load(32'h44, d, st);
    check(st == 0 && d == exp, "R6 merged hit", d, exp);
  endtask

  task automatic t_store_miss();
    logic [31:0] d; int st;
    cpu_store(32'h300, 32'hDEAD_BEEF, 4'hF, st);
    check(last_w_addr == 32'h300, "R7 store miss written", last_w_addr, 32'h300);
    cpu_load(32'h300, d, st);
    check(st == 2, "R7 no allocate on store miss", st, 2);
    check(d == 32'hDEAD_BEEF, "R7 data from memory", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_snoop();
    logic [31:0] d; int st;
    snoop_pulse(1'b0, 32'h48);
    cpu_load(32'h40, d, st);
    check(st == 0, "R8 snoop disabled no effect", st, 0);
    snoop_pulse(1'b1, 32'h4C);
    cpu_load(32'h40, d, st);
    check(st == 2, "R8 snoop invalidates line", st, 2);
  endtask

  task automatic t_snoop_refill();
    logic [31:0] d; int st;
    fork
      cpu_load(32'h500, d, st);
      begin
        repeat (3) @(negedge clk);
        snoop_en = 1; snoop_valid = 1; snoop_addr = 32'h508;
        @(negedge clk); snoop_valid = 0; snoop_en = 0;
      end
    join
    check(d == mem[320], "R9 critical word still returned", d, mem[320]);
    cpu_load(32'h50C, d, st);
    check(st == 2, "R9 line left invalid", st, 2);
  endtask

  task automatic t_inv_all();
    logic [31:0] d; int st;
    cpu_load(32'h80, d, st);
    cpu_load(32'h84, d, st);
    check(st == 0, "R10 line filled", st, 0);
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
    cpu_load(32'h84, d, st);
    check(st == 2, "R10 invalidate all", st, 2);
  endtask

  task automatic t_conflict();
    logic [31:0] d; int st;
    cpu_load(32'hC0, d, st);
    cpu_load(32'h4C0, d, st);
    check(st == 2 && d == mem[304], "R11 conflicting tag miss", d, mem[304]);
    cpu_load(32'hC0, d, st);
    check(st == 2, "R11 old tag replaced", st, 2);
  endtask

  task automatic t_ack_wait();
    int st;
    ack_wait = 3;
    cpu_store(32'h60, 32'h0BAD_F00D, 4'hF, st);
    check(st == 4, "R12 store waits for ack", st, 4);
    check(last_w_data == 32'h0BAD_F00D, "R12 data held through wait", last_w_data, 32'h0BAD_F00D);
    ack_wait = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset_miss();
    t_burst4_hits();
    t_burst1();
    t_store_hit();
    t_store_miss();
    t_snoop();
    t_snoop_refill();
    t_inv_all();
    t_conflict();
    t_ack_wait();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule